// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block turns whole read and write requests for a byte-addressed serial EEPROM into the sequence of byte-level bus primitives that an I2C master carries out. It supports three device sizes: 2 KB, 8 KB (8191 usable bytes, because the top byte controls write protection) and 16 KB. A request gives a direction, a start address, a byte count and a size mode. Read data leaves on a valid/ready stream. Write data is fetched by byte index, so a write burst can be replayed from its first byte.

Every transfer starts with an addressing phase. This is a dummy write that carries the address. It is retried with a backoff that grows linearly when the device stays silent. Reads follow it with a repeated start. Writes are cut into page bursts. Each burst is closed with a stop and followed by the programmable write-cycle wait. If a data byte is not acknowledged, the whole write request starts again from its original address. A microsecond tick derived from the clock frequency times both the backoff and the write-cycle wait.

Top module: `eeprom_seq`

## Requirements
- R1: The addressing phase is START, then a select byte, then the address. The base select value is 0xA0 in the 2 KB mode (req_mode=0) and the 16 KB mode (req_mode=2), and 0x80 in the 8 KB mode (req_mode=1). In the 2 KB and 8 KB modes the select byte is the base value ORed with (address>>8)<<1, followed by the low address byte. In the 16 KB mode the plain base value, the high address byte and the low address byte are sent, and the acknowledge of the select byte is ignored.
- R2: After a successful addressing phase, a read issues START and then the base select value with bit 0 set. In the 2 KB and 8 KB modes, (address>>8)<<1 is also ORed into this byte.
- R3: A read acknowledges every received byte except the last one. The last byte gets NACK and is followed by STOP. Each byte is offered on rd_valid/rd_data until rd_ready is seen.
- R4: A request is shortened so that it ends at the last byte of the device. The sizes are 2048, 8191 and 16384 bytes. done_count reports the bytes actually moved.
- R5: A request whose start address is at or beyond the device size causes no bus activity. It finishes with done_count=0 and done_err=2 for a read or done_err=3 for a write. A request with a count of zero finishes with no bus activity and done_err=0.
- R6: Writes go out in bursts that never cross a page. Pages are 16 bytes in the 2 KB and 8 KB modes and 64 bytes in the 16 KB mode. Each burst ends with STOP, and the next START comes no earlier than wcycle_us microseconds later.
- R7: An addressing attempt that is not acknowledged ends with STOP. Before retry k (k=1..9) the block waits k·BACKOFF_US microseconds. After 10 failed attempts the request finishes with done_err=1.
- R8: A data byte that is not acknowledged ends the burst with STOP and the write-cycle wait. The request then restarts from its original address and byte index 0. When 10 passes fail, the request finishes with done_err=4.
- R9: retry_stb pulses once at the end of each addressing phase. retry_cnt holds the number of failed attempts before success, or 10 when addressing gives up.
- R10: After reset, req_ready=1 and busy, done and prim_valid are 0. busy stays high from the accepting cycle through the done cycle, and req_ready is high only while idle.
- R11: done pulses for one cycle at the end of every request, together with done_count and done_err. done_err is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 = 2 KB, 1 = 8 KB, 2 = 16 KB |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Bytes requested |
| wcycle_us | input | UW | Write-cycle wait in microseconds |
| wr_req | output | 1 | Write byte wanted |
| wr_idx | output | CW | Index of the wanted write byte |
| wr_valid | input | 1 | Write byte supplied |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte taken |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| done_count | output | CW | Bytes transferred |
| done_err | output | 3 | 0 ok, 1 addressing, 2 read range, 3 no space, 4 write failure |
| retry_stb | output | 1 | Addressing phase finished |
| retry_cnt | output | 4 | Failed addressing attempts |
| prim_valid | output | 1 | Primitive command pulse |
| prim_op | output | 3 | 0 START, 1 STOP, 2 WRITE, 3 READ, 4 ACK, 5 NACK |
| prim_data | output | 8 | Byte for WRITE |
| prim_done | input | 1 | Primitive finished |
| prim_ack | input | 1 | Device acknowledged the WRITE |
| prim_rdata | input | 8 | Byte from READ |

## Verification
Each primitive command pulses one cycle after the cycle in which the previous command's prim_done is registered. done is due one cycle after the final STOP completes, and one cycle after acceptance for a rejected or empty request. retry_stb is due one cycle after the low address byte is acknowledged. A wait of N microseconds lasts exactly N·(CLK_HZ/1e6) cycles from the cycle after its STOP completes. For these reasons the bench drives and samples on falling edges and waits for done instead of counting a fixed latency. It measures gaps between STOP and START against lower bounds, and the backoff gaps against a window only a few cycles wide.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_ACK   = 3'd4,
    OP_NACK  = 3'd5
  } prim_op_e;

  localparam logic [1:0] MODE_8K  = 2'd1;
  localparam logic [1:0] MODE_16K = 2'd2;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_ADDR    = 3'd1;
  localparam logic [2:0] ERR_RANGE   = 3'd2;
  localparam logic [2:0] ERR_NOSPACE = 3'd3;
  localparam logic [2:0] ERR_WRITE   = 3'd4;

endpackage

// File: rtl/eeprom_seq_geom.sv
module eeprom_seq_geom
  import eeprom_seq_pkg::*;
#(
  parameter int SW = 15
) (
  input  logic [1:0]    mode,
  output logic [SW-1:0] size,
  output logic [6:0]    page_mask,
  output logic [7:0]    sel,
  output logic          wide
);

  always_comb begin
    case (mode)
      MODE_8K: begin
        size = SW'(8191); page_mask = 7'd15; sel = 8'h80; wide = 1'b0;
      end
      MODE_16K: begin
        size = SW'(16384); page_mask = 7'd63; sel = 8'hA0; wide = 1'b1;
      end
      default: begin
        size = SW'(2048); page_mask = 7'd15; sel = 8'hA0; wide = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
  parameter int TICK_DIV = 250,
  parameter int UW       = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [UW-1:0] load_us,
  output logic          expired
);

  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic [UW-1:0] left_q, left_d;
  logic          tick;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_comb begin
    div_d  = div_q;
    left_d = left_q;
    if (start) begin
      div_d  = '0;
      left_d = load_us;
    end else if (left_q != '0) begin
      if (tick) begin
        div_d  = '0;
        left_d = left_q - 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      left_q <= '0;
    end else begin
      div_q  <= div_d;
      left_q <= left_d;
    end
  end

  assign expired = (left_q == '0);

  // R6 / R7: a running wait never grows unless it is reloaded
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && left_q != '0) |=> (left_q <= $past(left_q)));

  // R7: the divider stays inside its range
  a_r7_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_q) < TICK_DIV);

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int BACKOFF_US = 1000,
  parameter int AW         = 14,
  parameter int CW         = 15,
  parameter int UW         = 20,
  parameter int MAX_TRIES  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [UW-1:0] wcycle_us,
  output logic          wr_req,
  output logic [CW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  input  logic          rd_ready,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] done_count,
  output logic [2:0]    done_err,
  output logic          retry_stb,
  output logic [3:0]    retry_cnt,
  output logic          prim_valid,
  output logic [2:0]    prim_op,
  output logic [7:0]    prim_data,
  input  logic          prim_done,
  input  logic          prim_ack,
  input  logic [7:0]    prim_rdata
);

  localparam int SW       = AW + 1;
  localparam int TICK_DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  typedef enum logic [4:0] {
    S_IDLE, S_BACKOFF, S_ASTART, S_ASEL, S_AHI, S_ALO, S_AFAIL,
    S_RSTART, S_RSEL, S_RBYTE, S_RPUSH, S_RACK, S_RNACK,
    S_WFETCH, S_WBYTE, S_WSTOP, S_WWAIT, S_STOP, S_DONE
  } state_e;

  state_e        st_q, st_d;
  logic          pend_q, pend_d;
  logic          wr_q, wr_d, wfail_q, wfail_d;
  logic [1:0]    mode_q, mode_d;
  logic [SW-1:0] base_q, base_d, cur_q, cur_d;
  logic [CW-1:0] eff_q, eff_d, xfer_q, xfer_d;
  logic [3:0]    att_q, att_d, pass_q, pass_d;
  logic [7:0]    rbuf_q, rbuf_d, data_q, data_d;
  logic [2:0]    err_q, err_d;
  logic          stb_q, stb_d;
  logic [3:0]    rcnt_q, rcnt_d;

  logic [1:0]    g_mode;
  logic [SW-1:0] g_size, room;
  logic [6:0]    g_mask;
  logic [7:0]    g_sel, pg8;
  logic          g_wide;
  logic          tmr_go, tmr_exp;
  logic [UW-1:0] tmr_load;
  logic          cmd_st, adv;
  prim_op_e      op_c;
  logic [7:0]    dat_c;

  assign g_mode = (st_q == S_IDLE) ? req_mode : mode_q;

  eeprom_seq_geom #(.SW(SW)) u_geom (
    .mode(g_mode), .size(g_size), .page_mask(g_mask), .sel(g_sel), .wide(g_wide)
  );

  eeprom_seq_timer #(.TICK_DIV(TICK_DIV), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_go), .load_us(tmr_load), .expired(tmr_exp)
  );

  assign pg8  = 8'(cur_q >> 8);
  assign room = g_size - SW'(req_addr);

  always_comb begin
    cmd_st = 1'b1;
    dat_c  = 8'h00;
    op_c   = OP_START;
    case (st_q)
      S_ASTART, S_RSTART:          op_c = OP_START;
      S_AFAIL, S_WSTOP, S_STOP:    op_c = OP_STOP;
      S_ASEL: begin op_c = OP_WRITE; dat_c = g_wide ? g_sel : (g_sel | (pg8 << 1)); end
      S_AHI:  begin op_c = OP_WRITE; dat_c = pg8; end
      S_ALO:  begin op_c = OP_WRITE; dat_c = cur_q[7:0]; end
      S_RSEL: begin op_c = OP_WRITE; dat_c = g_wide ? (g_sel | 8'h01) : (g_sel | 8'h01 | (pg8 << 1)); end
      S_WBYTE: begin op_c = OP_WRITE; dat_c = data_q; end
      S_RBYTE:                     op_c = OP_READ;
      S_RACK:                      op_c = OP_ACK;
      S_RNACK:                     op_c = OP_NACK;
      default:                     cmd_st = 1'b0;
    endcase
  end

  assign prim_valid = cmd_st && !pend_q;
  assign prim_op    = op_c;
  assign prim_data  = dat_c;
  assign adv        = pend_q && prim_done;

  always_comb begin
    st_d = st_q; pend_d = pend_q; wr_d = wr_q; wfail_d = wfail_q; mode_d = mode_q;
    base_d = base_q; cur_d = cur_q; eff_d = eff_q; xfer_d = xfer_q;
    att_d = att_q; pass_d = pass_q; rbuf_d = rbuf_q; data_d = data_q; err_d = err_q;
    stb_d = 1'b0; rcnt_d = rcnt_q; tmr_go = 1'b0; tmr_load = wcycle_us;
    if (prim_valid)  pend_d = 1'b1;
    else if (adv)    pend_d = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        wr_d = req_write; mode_d = req_mode; base_d = SW'(req_addr); cur_d = SW'(req_addr);
        xfer_d = '0; att_d = '0; pass_d = '0; err_d = ERR_NONE; eff_d = '0;
        if (32'(req_addr) >= 32'(g_size)) begin
          err_d = req_write ? ERR_NOSPACE : ERR_RANGE;
          st_d  = S_DONE;
        end else if (req_count == '0) begin
          st_d = S_DONE;
        end else begin
          eff_d = (32'(req_count) > 32'(room)) ? CW'(room) : req_count;
          st_d  = S_ASTART;
        end
      end
      S_BACKOFF: if (tmr_exp) st_d = S_ASTART;
      S_ASTART:  if (adv) st_d = S_ASEL;
      S_ASEL:    if (adv) st_d = g_wide ? S_AHI : (prim_ack ? S_ALO : S_AFAIL);
      S_AHI:     if (adv) st_d = prim_ack ? S_ALO : S_AFAIL;
      S_ALO: if (adv) begin
        if (prim_ack) begin
          stb_d = 1'b1; rcnt_d = att_q;
          st_d  = wr_q ? S_WFETCH : S_RSTART;
        end else begin
          st_d = S_AFAIL;
        end
      end
      S_AFAIL: if (adv) begin
        if (32'(att_q) == MAX_TRIES - 1) begin
          stb_d = 1'b1; rcnt_d = 4'(MAX_TRIES); err_d = ERR_ADDR; st_d = S_DONE;
        end else begin
          att_d    = att_q + 1'b1;
          tmr_go   = 1'b1;
          tmr_load = UW'((32'(att_q) + 1) * BACKOFF_US);
          st_d     = S_BACKOFF;
        end
      end
      S_RSTART: if (adv) st_d = S_RSEL;
      S_RSEL: if (adv) begin
        if (prim_ack) st_d = S_RBYTE;
        else begin err_d = ERR_ADDR; st_d = S_STOP; end
      end
      S_RBYTE: if (adv) begin rbuf_d = prim_rdata; st_d = S_RPUSH; end
      S_RPUSH: if (rd_ready) begin
        xfer_d = xfer_q + 1'b1; cur_d = cur_q + 1'b1;
        st_d   = (xfer_q + 1'b1 == eff_q) ? S_RNACK : S_RACK;
      end
      S_RACK:  if (adv) st_d = S_RBYTE;
      S_RNACK: if (adv) st_d = S_STOP;
      S_WFETCH: if (wr_valid) begin data_d = wr_data; st_d = S_WBYTE; end
      S_WBYTE: if (adv) begin
        if (prim_ack) begin
          xfer_d  = xfer_q + 1'b1; cur_d = cur_q + 1'b1; wfail_d = 1'b0;
          st_d = ((xfer_q + 1'b1 == eff_q) || (((cur_q + 1'b1) & SW'(g_mask)) == '0))
                 ? S_WSTOP : S_WFETCH;
        end else begin
          wfail_d = 1'b1; st_d = S_WSTOP;
        end
      end
      S_WSTOP: if (adv) begin tmr_go = 1'b1; tmr_load = wcycle_us; st_d = S_WWAIT; end
      S_WWAIT: if (tmr_exp) begin
        att_d = '0;
        if (wfail_q) begin
          if (32'(pass_q) == MAX_TRIES - 1) begin err_d = ERR_WRITE; st_d = S_DONE; end
          else begin
            pass_d = pass_q + 1'b1; cur_d = base_q; xfer_d = '0; st_d = S_ASTART;
          end
        end else begin
          st_d = (xfer_q == eff_q) ? S_DONE : S_ASTART;
        end
      end
      S_STOP: if (adv) st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; pend_q <= 1'b0; wr_q <= 1'b0; wfail_q <= 1'b0; mode_q <= '0;
      base_q <= '0; cur_q <= '0; eff_q <= '0; xfer_q <= '0; att_q <= '0; pass_q <= '0;
      rbuf_q <= '0; data_q <= '0; err_q <= ERR_NONE; stb_q <= 1'b0; rcnt_q <= '0;
    end else begin
      st_q <= st_d; pend_q <= pend_d; wr_q <= wr_d; wfail_q <= wfail_d; mode_q <= mode_d;
      base_q <= base_d; cur_q <= cur_d; eff_q <= eff_d; xfer_q <= xfer_d; att_q <= att_d;
      pass_q <= pass_d; rbuf_q <= rbuf_d; data_q <= data_d; err_q <= err_d;
      stb_q <= stb_d; rcnt_q <= rcnt_d;
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign busy       = (st_q != S_IDLE);
  assign done       = (st_q == S_DONE);
  assign done_count = xfer_q;
  assign done_err   = err_q;
  assign rd_valid   = (st_q == S_RPUSH);
  assign rd_data    = rbuf_q;
  assign wr_req     = (st_q == S_WFETCH);
  assign wr_idx     = xfer_q;
  assign retry_stb  = stb_q;
  assign retry_cnt  = rcnt_q;

  // R10: an accepted request raises busy in the next cycle
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R11: done is followed by readiness for the next request
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R3: only one primitive command is in flight
  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |=> !prim_valid);
  // R4: never more bytes than the shortened count
  a_r4_xfer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q <= eff_q);
  // R7: attempt index stays below the limit
  a_r7_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(att_q) < MAX_TRIES);
  // R8: pass index stays below the limit
  a_r8_pass_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pass_q) < MAX_TRIES);
  // R9: reported retries never exceed the attempt limit
  a_r9_strobe_range: assert property (@(posedge clk) disable iff (!rst_n)
    retry_stb |-> (32'(retry_cnt) <= MAX_TRIES));
  // R5: a rejected request produces no bus command
  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && 32'(req_addr) >= 32'(g_size)) |=> (!prim_valid && done));
  // R6: an acknowledged byte at a page end closes the burst
  a_r6_page_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WBYTE && adv && prim_ack && (((cur_q + 1'b1) & SW'(g_mask)) == '0))
    |=> (st_q == S_WSTOP));

endmodule

// File: tb/eeprom_seq_tb.sv
`timescale 1ns/1ps
module eeprom_seq_tb;
  import eeprom_seq_pkg::*;

  localparam int TICK = 2;
  localparam int BOFF = 4;
  localparam int WCYC = 6;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic req_valid, req_ready, req_write;
  logic [1:0] req_mode;
  logic [13:0] req_addr;
  logic [14:0] req_count;
  logic [19:0] wcycle_us;
  logic wr_req, wr_valid, rd_valid, rd_ready, busy, done, retry_stb;
  logic [14:0] wr_idx, done_count;
  logic [7:0] wr_data, rd_data, prim_data, prim_rdata;
  logic [2:0] done_err, prim_op;
  logic [3:0] retry_cnt;
  logic prim_valid, prim_done, prim_ack;

  eeprom_seq #(.CLK_HZ(2_000_000), .BACKOFF_US(BOFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_count(req_count), .wcycle_us(wcycle_us), .wr_req(wr_req), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .busy(busy), .done(done), .done_count(done_count),
    .done_err(done_err), .retry_stb(retry_stb), .retry_cnt(retry_cnt),
    .prim_valid(prim_valid), .prim_op(prim_op), .prim_data(prim_data),
    .prim_done(prim_done), .prim_ack(prim_ack), .prim_rdata(prim_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [int];
  int mmode, ph, ptr, rmode, last_rsel, seed;
  int nack_sel, nack_data_at, nack_data_all;
  int sel_bad, page_bad, burst_page, in_data, sel_nacked;
  int starts, reads, acks, nacks, wbytes, min_wgap, last_stop, stop_kind, stb_n, last_rcnt;
  int gaps[$];
  logic [7:0] rxq[$];

  function automatic logic [7:0] mrd(input int a);
    return mem.exists(a) ? mem[a] : 8'(a * 3 + 1);
  endfunction
  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 13 + s);
  endfunction

  task automatic serve(input logic [2:0] op, input logic [7:0] d);
    int pg, pmask, pge;
    logic [7:0] expb;
    pg    = (mmode == 2) ? 64 : 16;
    pmask = (mmode == 1) ? 31 : 7;
    expb  = (mmode == 1) ? 8'h80 : 8'hA0;
    prim_ack = 1'b1;
    case (op)
      3'd0: begin
        if (stop_kind == 1 && cyc - last_stop < min_wgap) min_wgap = cyc - last_stop;
        if (stop_kind == 2) gaps.push_back(cyc - last_stop);
        stop_kind = 0; ph = 0; rmode = 0; starts++;
      end
      3'd1: begin
        last_stop = cyc;
        stop_kind = in_data ? 1 : (sel_nacked ? 2 : 0);
        in_data = 0; sel_nacked = 0;
      end
      3'd2: begin
        if (ph == 0) begin
          if (mmode == 2) begin
            if ((d & 8'hFE) != expb) sel_bad++;
            pge = 0;
          end else begin
            pge = (d >> 1) & pmask;
            if ((d & ~8'(pmask << 1) & 8'hFE) != expb) sel_bad++;
          end
          if (d[0]) begin
            rmode = 1; last_rsel = d;
            if (mmode != 2 && pge != (ptr >> 8)) sel_bad++;
          end else begin
            ptr = pge << 8;
            ph = (mmode == 2) ? 1 : 2;
            if (nack_sel > 0) begin nack_sel--; prim_ack = 1'b0; sel_nacked = 1; end
          end
        end else if (ph == 1) begin
          ptr = int'(d) << 8; ph = 2;
        end else if (ph == 2) begin
          ptr = ptr | int'(d); ph = 3;
        end else begin
          in_data = 1; wbytes++;
          if (nack_data_all != 0) prim_ack = 1'b0;
          else if (nack_data_at == 0) begin prim_ack = 1'b0; nack_data_at = -1; end
          else if (nack_data_at > 0) nack_data_at--;
          if (prim_ack) begin
            if (in_data == 1 && burst_page < 0) burst_page = ptr / pg;
            else if (ptr / pg != burst_page) page_bad++;
            mem[ptr] = d; ptr++;
          end
        end
      end
      3'd3: begin prim_rdata = mrd(ptr); ptr++; reads++; end
      3'd4: acks++;
      default: nacks++;
    endcase
    if (op == 3'd1) burst_page = -1;
  endtask

  initial begin
    prim_done = 1'b0; prim_ack = 1'b0; prim_rdata = 8'h00;
    forever begin
      @(negedge clk);
      prim_done = 1'b0;
      if (prim_valid) begin
        logic [2:0] o; logic [7:0] dd;
        o = prim_op; dd = prim_data;
        @(negedge clk);
        serve(o, dd);
        prim_done = 1'b1;
      end
    end
  end

  // write data source and read sink
  initial begin
    wr_valid = 1'b0; wr_data = 8'h00; rd_ready = 1'b0;
    forever begin
      @(negedge clk);
      wr_valid = wr_req;
      wr_data  = pat(int'(wr_idx), seed);
      rd_ready = (cyc % 3) != 0;
      if (rd_valid && rd_ready) rxq.push_back(rd_data);
      if (retry_stb) begin stb_n++; last_rcnt = int'(retry_cnt); end
    end
  end

  int dcnt, derr, dbusy;
  task automatic run(input bit w, input int mode, input int addr, input int cnt);
    int n;
    mmode = mode; starts = 0; reads = 0; acks = 0; nacks = 0; wbytes = 0;
    sel_bad = 0; page_bad = 0; min_wgap = 1000000; stb_n = 0; last_rcnt = -1;
    burst_page = -1; gaps.delete(); rxq.delete(); ptr = addr;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_mode = 2'(mode);
    req_addr = 14'(addr); req_count = 15'(cnt);
    @(negedge clk);
    req_valid = 1'b0; dbusy = busy;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(1'b0, "R11 watchdog", n, 0);
    dcnt = int'(done_count); derr = int'(done_err);
  endtask

  typedef struct packed {
    logic w; logic [1:0] mode; logic [13:0] addr; logic [14:0] cnt;
    logic [14:0] ecnt; logic [2:0] eerr;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 14'd499,   15'd20, 15'd20, 3'd0},
    '{1'b0, 2'd0, 14'd499,   15'd20, 15'd20, 3'd0},
    '{1'b0, 2'd0, 14'd2040,  15'd20, 15'd8,  3'd0},
    '{1'b0, 2'd0, 14'd2048,  15'd4,  15'd0,  3'd2},
    '{1'b1, 2'd1, 14'd8190,  15'd4,  15'd1,  3'd0},
    '{1'b1, 2'd1, 14'd8191,  15'd2,  15'd0,  3'd3},
    '{1'b1, 2'd2, 14'd5000,  15'd70, 15'd70, 3'd0},
    '{1'b0, 2'd2, 14'd5000,  15'd70, 15'd70, 3'd0},
    '{1'b0, 2'd2, 14'd16380, 15'd10, 15'd4,  3'd0},
    '{1'b0, 2'd1, 14'd6844,  15'd3,  15'd3,  3'd0},
    '{1'b0, 2'd0, 14'd5,     15'd1,  15'd1,  3'd0},
    '{1'b1, 2'd0, 14'd40,    15'd0,  15'd0,  3'd0}
  };

  initial begin
    #780000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad, e;
    logic [7:0] esel;
    req_valid = 1'b0; req_write = 1'b0; req_mode = 2'd0; req_addr = '0; req_count = '0;
    wcycle_us = 20'(WCYC); seed = 0; nack_sel = 0; nack_data_at = -1; nack_data_all = 0;
    stop_kind = 0; in_data = 0; sel_nacked = 0; last_stop = 0; burst_page = -1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1 && busy == 1'b0 && done == 1'b0 && prim_valid == 1'b0,
        "R10 reset state", {req_ready, busy, done, prim_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      seed = i;
      run(VECS[i].w, int'(VECS[i].mode), int'(VECS[i].addr), int'(VECS[i].cnt));
      chk(dcnt == int'(VECS[i].ecnt), "R4 done_count", dcnt, int'(VECS[i].ecnt));
      chk(derr == int'(VECS[i].eerr), "R11 done_err", derr, int'(VECS[i].eerr));
      chk(sel_bad == 0, "R1 select bytes", sel_bad, 0);
      chk(dbusy == 1, "R10 busy after accept", dbusy, 1);
      if (VECS[i].ecnt == 0)
        chk(starts == 0, "R5 no bus activity", starts, 0);
      else if (VECS[i].w) begin
        bad = 0;
        for (int k = 0; k < int'(VECS[i].ecnt); k++)
          if (mrd(int'(VECS[i].addr) + k) != pat(k, i)) bad++;
        chk(bad == 0, "R6 written bytes", bad, 0);
        chk(page_bad == 0, "R6 burst inside page", page_bad, 0);
        chk(min_wgap >= WCYC * TICK, "R6 write-cycle gap", min_wgap, WCYC * TICK);
        chk(stb_n == starts && last_rcnt == 0, "R9 strobe per address phase", stb_n, starts);
      end else begin
        bad = 0;
        for (int k = 0; k < rxq.size(); k++)
          if (rxq[k] != mrd(int'(VECS[i].addr) + k)) bad++;
        chk(bad == 0 && rxq.size() == int'(VECS[i].ecnt), "R3 read data", bad, 0);
        chk(acks == int'(VECS[i].ecnt) - 1 && nacks == 1, "R3 ack all but last", acks,
            int'(VECS[i].ecnt) - 1);
        esel = (VECS[i].mode == 2'd2) ? 8'hA1 :
               (((VECS[i].mode == 2'd1) ? 8'h80 : 8'hA0) | 8'h01 |
                8'(int'(VECS[i].addr >> 8) << 1));
        chk(last_rsel == int'(esel), "R2 read select", last_rsel, int'(esel));
      end
    end

    // R7 / R9: three refused attempts, then success
    nack_sel = 3;
    run(1'b0, 0, 300, 2);
    chk(derr == 0 && dcnt == 2, "R7 recovers after retries", derr, 0);
    chk(last_rcnt == 3 && stb_n == 1, "R9 retry count", last_rcnt, 3);
    chk(gaps.size() == 3, "R7 three backoffs", gaps.size(), 3);
    for (int k = 0; k < gaps.size(); k++) begin
      e = (k + 1) * BOFF * TICK;
      chk(gaps[k] >= e && gaps[k] < e + 10, "R7 backoff length", gaps[k], e);
    end

    // R7 / R9: give up after ten attempts
    nack_sel = 10;
    run(1'b0, 0, 300, 2);
    chk(derr == 1 && dcnt == 0, "R7 give up error", derr, 1);
    chk(starts == 10, "R7 ten attempts", starts, 10);
    chk(last_rcnt == 10, "R9 retry count on give up", last_rcnt, 10);

    // R8: one data NACK restarts the request from byte 0
    seed = 50; nack_data_at = 5;
    run(1'b1, 0, 32, 10);
    chk(derr == 0 && dcnt == 10, "R8 restart completes", dcnt, 10);
    chk(wbytes == 16, "R8 replay from first byte", wbytes, 16);
    bad = 0;
    for (int k = 0; k < 10; k++) if (mrd(32 + k) != pat(k, 50)) bad++;
    chk(bad == 0, "R8 data after restart", bad, 0);
    chk(min_wgap >= WCYC * TICK, "R8 wait after failed burst", min_wgap, WCYC * TICK);

    // R8: every pass refused
    nack_data_all = 1;
    run(1'b1, 0, 64, 3);
    nack_data_all = 0;
    chk(derr == 4, "R8 write failure error", derr, 4);
    chk(starts == 10, "R8 ten passes", starts, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule